// File: doc/BRIEF.md
# Two-Output Lookup Logic Cell

This block is a single cell of a datapath built from rows of identical cells. Four selectors each pick one bit from a shared operand bus, or from the cell's own registered outputs, to form a 4-bit address. That address reads two 16-entry truth tables at once, so one cell gives two independent functions of the same four inputs. Each of the two results goes to its output through either a plain wire or a register. The register captures only when the row controller raises its enable.

A carry mode turns the cell into one bit of a ripple adder. In this mode the third address bit comes from the neighbouring cell's carry instead of its selector, and the second table drives the carry output. The cell's whole function is loaded over a single-bit serial configuration input. A synchronous reset clears the output registers and leaves the loaded configuration in place.

Top module: `lut_cell`

## Requirements
- R1: While `cfg_en` is high, each rising clock edge shifts `cfg_din` into bit 0 of the 47-bit configuration word, and every other bit moves up one place. A word sent most-significant bit first is therefore in place after 47 clocks. While `cfg_en` is low the word does not change, whatever `cfg_din` does.
- R2: The configuration word is laid out as follows. Bits [15:0] hold table 0 and bits [31:16] hold table 1, each indexed by the address. Selector k (k = 0..3) sits at bits [32+3k+2 : 32+3k] and drives address bit k. Bit 44 is carry mode. Bit 45 is the bypass for `y[0]` and bit 46 is the bypass for `y[1]`.
- R3: A selector value v from 0 to 5 picks `opnd[v]`. Value 6 picks the registered state of `y[0]` and value 7 picks the registered state of `y[1]`.
- R4: LUT result i equals table i at the current address.
- R5: When the bypass bit for output i is set, `y[i]` equals LUT result i in the same cycle.
- R6: When the bypass bit for output i is clear, `y[i]` shows register i. That register loads LUT result i on a rising edge with `row_en` high and holds its value otherwise.
- R7: In carry mode, address bit 2 is taken from `carry_in` and `carry_out` equals LUT result 1. With full-adder tables, `y[0]` is the sum and `carry_out` is the majority of the two operands and `carry_in`. Outside carry mode, `carry_out` is 0.
- R8: When `rst` is high at a rising edge, both output registers clear to 0 and the configuration is kept.
- R9: Selecting a registered output as an input lets the cell hold state. With table 0 set to invert the registered `y[0]`, the output toggles on every enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset of the output registers |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data |
| opnd | input | 6 | Operand bus bits that the selectors can pick |
| carry_in | input | 1 | Carry from the preceding cell |
| row_en | input | 1 | Output register capture enable from the row controller |
| carry_out | output | 1 | Carry to the following cell |
| y | output | 2 | Cell outputs |

## Verification
The assertions assume that `rst` is high on the first clock edge, so the configuration history they inspect starts from a defined point. They also assume `cfg_en` is driven to a known level on every edge. The stimulus holds reset in the first cycle and drives every input at the falling edge. `row_en` and `rst` are kept low while a configuration is shifted in, so the registered state the bench models cannot move during a load. Output checks are skipped only during those load cycles.

// File: rtl/lut_cell.sv
module lut_cell #(
  parameter int SEL_W = 3,
  localparam int NSRC = 2 ** SEL_W,
  localparam int OPND_W = NSRC - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              cfg_din,
  input  logic [OPND_W-1:0] opnd,
  input  logic              carry_in,
  input  logic              row_en,
  output logic              carry_out,
  output logic [1:0]        y
);
  localparam int LUT_N   = 16;
  localparam int FLD_LO  = 2 * LUT_N;
  localparam int CRY_BIT = FLD_LO + 4 * SEL_W;
  localparam int BYP_LO  = CRY_BIT + 1;
  localparam int CFG_W   = BYP_LO + 2;

  logic [CFG_W-1:0] cfg;
  logic [LUT_N-1:0] tab0, tab1;
  logic [NSRC-1:0]  src;
  logic [3:0]       addr;
  logic [1:0]       lut_o, q, byp;
  logic             carry_mode;

  assign tab0       = cfg[LUT_N-1:0];
  assign tab1       = cfg[2*LUT_N-1:LUT_N];
  assign carry_mode = cfg[CRY_BIT];
  assign byp        = cfg[BYP_LO +: 2];
  assign src        = {q, opnd};

  always_comb begin
    for (int k = 0; k < 4; k++)
      addr[k] = src[cfg[FLD_LO + k*SEL_W +: SEL_W]];
    if (carry_mode) addr[2] = carry_in;
  end

  assign lut_o     = {tab1[addr], tab0[addr]};
  assign carry_out = carry_mode & lut_o[1];
  assign y         = (byp & lut_o) | (~byp & q);

  always_ff @(posedge clk)
    if (cfg_en) cfg <= {cfg[CFG_W-2:0], cfg_din};

  always_ff @(posedge clk)
    if (rst)         q <= 2'b00;
    else if (row_en) q <= lut_o;

  assert_cfg_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(cfg));
  assert_cfg_shift_R1: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> cfg[0] == $past(cfg_din));
  assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
    row_en |=> q == $past(lut_o));
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !row_en |=> $stable(q));
  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> q == 2'b00);
endmodule

// File: tb/sim_lut_cell.sv
`timescale 1ns/1ps
module sim_lut_cell;
  localparam int CFG_W = 47;
  logic clk = 1'b0;
  logic rst = 1'b1, cfg_en = 1'b0, cfg_din = 1'b0, carry_in = 1'b0, row_en = 1'b0;
  logic [5:0] opnd = '0;
  logic carry_out;
  logic [1:0] y;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [CFG_W-1:0] mcfg = '0;
  logic [1:0] mq = 2'b00;

  always #2.5 clk = ~clk;

  lut_cell u0 (.clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din), .opnd(opnd),
               .carry_in(carry_in), .row_en(row_en), .carry_out(carry_out), .y(y));

  function automatic logic [1:0] model(input logic [CFG_W-1:0] c, input logic [5:0] op,
                                       input logic ci, input logic [1:0] q);
    logic [7:0] s;
    logic [3:0] a;
    logic [15:0] t0, t1;
    s = {q, op};
    for (int k = 0; k < 4; k++) a[k] = s[c[32+3*k +: 3]];
    if (c[44]) a[2] = ci;
    t0 = c[15:0];
    t1 = c[31:16];
    return {t1[a], t0[a]};
  endfunction

  function automatic logic [15:0] table_of(input int kind);
    logic [15:0] t;
    for (int i = 0; i < 16; i++) begin
      logic a, b, c;
      a = i[0]; b = i[1]; c = i[2];
      case (kind)
        0: t[i] = a & b;
        1: t[i] = a | b;
        2: t[i] = a ^ b ^ c;
        3: t[i] = (a & b) | (a & c) | (b & c);
        4: t[i] = ~a;
        default: t[i] = b;
      endcase
    end
    return t;
  endfunction

  function automatic logic [CFG_W-1:0] make_cfg(input logic [15:0] t0, input logic [15:0] t1,
      input logic [2:0] s0, input logic [2:0] s1, input logic [2:0] s2, input logic [2:0] s3,
      input logic cm, input logic [1:0] bp);
    return {bp, cm, s3, s2, s1, s0, t1, t0};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load(input logic [CFG_W-1:0] c);
    for (int i = CFG_W-1; i >= 0; i--) begin
      @(negedge clk);
      rst = 0; row_en = 0; cfg_en = 1; cfg_din = c[i];
      @(posedge clk);
    end
    mcfg = c;
  endtask

  task automatic cycle(input logic [5:0] op, input logic ci, input logic en, input logic r,
                       input string tag);
    logic [1:0] lo, ey;
    @(negedge clk);
    cfg_en = 0; cfg_din = 1'($urandom); opnd = op; carry_in = ci; row_en = en; rst = r;
    #1;
    lo = model(mcfg, op, ci, mq);
    for (int i = 0; i < 2; i++) begin
      ey[i] = mcfg[45+i] ? lo[i] : mq[i];
      check(tag != "" ? tag : (mcfg[45+i] ? "R5" : "R6"), int'(y[i]), int'(ey[i]));
    end
    check(tag != "" ? tag : "R7", int'(carry_out), int'(mcfg[44] & lo[1]));
    @(posedge clk);
    if (r) mq = 2'b00;
    else if (en) mq = lo;
  endtask

  initial begin
    logic [CFG_W-1:0] c;
    void'($urandom(32'd1234));
    // R8: reset state with a registered configuration
    load(make_cfg(table_of(0), table_of(1), 3'd0, 3'd1, 3'd2, 3'd3, 1'b0, 2'b00));
    cycle(6'h3f, 0, 1, 1, "R8");
    #1; check("R8", int'(y), 0);
    // R4 R5: AND and OR gates, bypassed, all input pairs
    load(make_cfg(table_of(0), table_of(1), 3'd2, 3'd4, 3'd0, 3'd1, 1'b0, 2'b11));
    for (int v = 0; v < 4; v++)
      cycle({1'b0, v[1], 1'b0, v[0], 2'b00}, 0, 0, 0, "R4");
    // R1: cfg_din toggles with cfg_en low, function stays
    for (int v = 0; v < 4; v++)
      cycle({1'b0, v[1], 1'b0, v[0], 2'b00}, 0, 0, 0, "R1");
    // R7: full adder bit, every operand and carry combination
    load(make_cfg(table_of(2), table_of(3), 3'd0, 3'd1, 3'd5, 3'd4, 1'b1, 2'b11));
    for (int v = 0; v < 8; v++) begin
      logic [5:0] op;
      op = 6'($urandom);
      op[0] = v[0]; op[1] = v[1];
      cycle(op, v[2], 1, 0, "R7");
      check("R7", int'({carry_out, y[0]}), v[0] + v[1] + v[2]);
    end
    // R9 R3: y0 toggles from its own state, y1 copies the previous y0
    load(make_cfg(table_of(4), table_of(5), 3'd6, 3'd6, 3'd0, 3'd0, 1'b0, 2'b00));
    cycle(6'h00, 0, 0, 1, "R8");
    for (int n = 0; n < 6; n++) begin
      cycle(6'($urandom), 0, 1, 0, "R9");
      #1; check("R9", int'(y[0]), (n + 1) % 2);
      check("R3", int'(y[1]), n % 2);
    end
    cycle(6'h00, 0, 0, 0, "R6");
    // R8: reset keeps configuration, toggling resumes
    cycle(6'h00, 0, 1, 1, "R8");
    cycle(6'h00, 0, 1, 0, "R8");
    #1; check("R8", int'(y[0]), 1);
    // R2 R4 R5 R6 R7: random configurations and traffic
    for (int k = 0; k < 30; k++) begin
      c = {15'($urandom), $urandom};
      load(c);
      for (int n = 0; n < 30; n++)
        cycle(6'($urandom), 1'($urandom), 1'($urandom), ($urandom % 16) == 0, "");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule